// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one switch of a two-dimensional mesh network-on-chip. It has four neighbour links (north, east, south, west) and a local resource port. Packets are 128 bits wide and cross a link in one cycle. The switch holds no queue. Every packet that arrives in a cycle leaves in the next cycle on some output. A packet that cannot take a direction toward its destination is deflected onto another free link, and its age field is incremented. Older packets are served first, so a packet that has been deflected many times gains priority.

The node's own coordinates and the mesh size are parameters. East is the direction of increasing X and south is the direction of increasing Y. A node on the boundary of the mesh has fewer than four neighbour links. On such a node the links with no neighbour are never driven, and anything presented on their inputs is ignored. The local resource offers a packet on `inj_pkt`. `inj_ack` tells it in the same cycle whether the switch took that packet. A packet addressed to the node leaves on `ej_pkt`.

Top module: `defl_router`

## Requirements
- R1: A packet is 128 bits. Bit 0 is the valid flag, bits 4:1 hold the destination X, bits 8:5 hold the destination Y, bits 12:9 hold the age, and bits 127:13 are payload. An input whose bit 0 is low carries no packet, and an output with no packet assigned is all zeros.
- R2: All outputs are registered. A packet accepted on one clock edge is visible on its output after that edge. An active-low asynchronous reset clears every output to zero.
- R3: Each accepted packet appears on exactly one output one cycle later. Its destination and payload are unchanged.
- R4: A packet whose destination equals the node's coordinates goes to `ej_pkt`, and at most one packet is ejected per cycle. This includes a packet injected from the local port.
- R5: A packet for another node takes a productive link when one is free: east if destination X is greater than node X, west if it is less, south if destination Y is greater than node Y, north if it is less. The X direction is tried before the Y direction.
- R6: Packets are served in order of decreasing age. Ties are broken by the fixed order north, east, south, west, injected.
- R7: A packet that gets neither ejection nor a productive link is deflected to the first free existing link in the order north, east, south, west. Its age is incremented and saturates at 15. Packets that are not deflected keep their age.
- R8: `inj_ack` is high exactly when `inj_pkt` is valid and the number of valid packets on existing neighbour inputs is less than the number of existing links. An injected packet is accepted only when `inj_ack` is high.
- R9: A link with no neighbour (north on row 0, south on the last row, west on column 0, east on the last column) never carries an output packet, and its input is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_n | input | 128 | Packet arriving from the north neighbour |
| in_e | input | 128 | Packet arriving from the east neighbour |
| in_s | input | 128 | Packet arriving from the south neighbour |
| in_w | input | 128 | Packet arriving from the west neighbour |
| inj_pkt | input | 128 | Packet offered by the local resource |
| inj_ack | output | 1 | The offered packet is taken this cycle |
| out_n | output | 128 | Registered packet toward the north neighbour |
| out_e | output | 128 | Registered packet toward the east neighbour |
| out_s | output | 128 | Registered packet toward the south neighbour |
| out_w | output | 128 | Registered packet toward the west neighbour |
| ej_pkt | output | 128 | Registered packet delivered to the local resource |

## Verification
The switch keeps no state beyond its output registers, so any allocation fault shows at the ports on the very next clock edge. A faulty allocator may lose or duplicate a packet, which changes the number of valid outputs against the number of valid inputs. It may also route a packet to the wrong port or age it wrongly, which gives a header on an unexpected port. A wrong priority order or tie-break only appears when packets contend, so the stimulus combines dense random traffic with directed collisions of equal and unequal ages. Boundary nodes are exercised as well, since a link without a neighbour changes both the injection limit and the set of ports available for deflection.

// File: rtl/defl_router.sv
module defl_router #(
  parameter int PKT_W  = 128,
  parameter int CW     = 4,
  parameter int AW     = 4,
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PKT_W-1:0] in_n,
  input  logic [PKT_W-1:0] in_e,
  input  logic [PKT_W-1:0] in_s,
  input  logic [PKT_W-1:0] in_w,
  input  logic [PKT_W-1:0] inj_pkt,
  output logic             inj_ack,
  output logic [PKT_W-1:0] out_n,
  output logic [PKT_W-1:0] out_e,
  output logic [PKT_W-1:0] out_s,
  output logic [PKT_W-1:0] out_w,
  output logic [PKT_W-1:0] ej_pkt
);
  localparam int XL = 1;
  localparam int YL = 1 + CW;
  localparam int AL = 1 + 2 * CW;
  localparam logic [CW-1:0] MX = CW'(NODE_X);
  localparam logic [CW-1:0] MY = CW'(NODE_Y);
  localparam logic [AW-1:0] AMAX = '1;
  localparam logic [3:0] LINK = {NODE_X > 0, NODE_Y < MESH_Y - 1, NODE_X < MESH_X - 1, NODE_Y > 0};
  localparam int NLINK = int'(LINK[0]) + int'(LINK[1]) + int'(LINK[2]) + int'(LINK[3]);

  logic [PKT_W-1:0] pin [5];
  logic [PKT_W-1:0] nxt [5];
  logic [4:0]       vld;

  assign pin[0] = in_n;
  assign pin[1] = in_e;
  assign pin[2] = in_s;
  assign pin[3] = in_w;
  assign pin[4] = inj_pkt;

  assign vld[3:0] = {in_w[0], in_s[0], in_e[0], in_n[0]} & LINK;
  assign inj_ack  = inj_pkt[0] && ($countones(vld[3:0]) < NLINK);
  assign vld[4]   = inj_ack;

  always_comb begin : alloc
    logic [4:0]       busy;
    logic [3:0]       want;
    logic [PKT_W-1:0] p;
    logic [CW-1:0]    dx, dy;
    logic             done;
    int               rnk [5];
    int               t;
    busy = '0;
    want = '0;
    p    = '0;
    dx   = '0;
    dy   = '0;
    done = 1'b0;
    t    = 0;
    for (int k = 0; k < 5; k++) begin
      nxt[k] = '0;
      rnk[k] = 0;
    end
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        if (j != i && vld[j] &&
            (pin[j][AL+:AW] > pin[i][AL+:AW] ||
             (pin[j][AL+:AW] == pin[i][AL+:AW] && j < i)))
          rnk[i]++;
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 5; i++) begin
        if (vld[i] && rnk[i] == r) begin
          p    = pin[i];
          dx   = p[XL+:CW];
          dy   = p[YL+:CW];
          done = 1'b0;
          if (dx == MX && dy == MY && !busy[4]) begin
            busy[4] = 1'b1;
            nxt[4]  = p;
            done    = 1'b1;
          end
          want = {dx < MX, dy > MY, dx > MX, dy < MY} & LINK & ~busy[3:0];
          t = -1;
          if (want[1]) t = 1;
          else if (want[3]) t = 3;
          else if (want[2]) t = 2;
          else if (want[0]) t = 0;
          if (!done && t >= 0) begin
            busy[t] = 1'b1;
            nxt[t]  = p;
            done    = 1'b1;
          end
          for (int k = 0; k < 4; k++) begin
            if (!done && LINK[k] && !busy[k]) begin
              if (p[AL+:AW] != AMAX) p[AL+:AW] = p[AL+:AW] + AW'(1);
              busy[k] = 1'b1;
              nxt[k]  = p;
              done    = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_n  <= '0;
      out_e  <= '0;
      out_s  <= '0;
      out_w  <= '0;
      ej_pkt <= '0;
    end else begin
      out_n  <= nxt[0];
      out_e  <= nxt[1];
      out_s  <= nxt[2];
      out_w  <= nxt[3];
      ej_pkt <= nxt[4];
    end
  end
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk #(
  parameter int CW     = 4,
  parameter int AW     = 4,
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 1,
  parameter int HW     = 1 + 2 * CW + AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    in_v,
  input logic          inj_v,
  input logic          inj_ack,
  input logic [HW-1:0] o_n,
  input logic [HW-1:0] o_e,
  input logic [HW-1:0] o_s,
  input logic [HW-1:0] o_w,
  input logic [2*CW:0] o_ej
);
  localparam int XL = 1;
  localparam int YL = 1 + CW;
  localparam int AL = 1 + 2 * CW;
  localparam logic [CW-1:0] MX = CW'(NODE_X);
  localparam logic [CW-1:0] MY = CW'(NODE_Y);
  localparam logic [3:0] LINK = {NODE_X > 0, NODE_Y < MESH_Y - 1, NODE_X < MESH_X - 1, NODE_Y > 0};

  logic       armed;
  logic [3:0] ov;
  int         in_cnt, out_cnt;

  assign ov      = {o_w[0], o_s[0], o_e[0], o_n[0]};
  assign in_cnt  = $countones(in_v & LINK) + int'(inj_ack);
  assign out_cnt = $countones(ov) + int'(o_ej[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  function automatic logic aged_ok(input logic [HW-1:0] h, input logic prod);
    return !h[0] || prod || h[AL+:AW] != '0;
  endfunction

  assert_conserve_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_cnt == $past(in_cnt));

  assert_eject_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    o_ej[0] |-> (o_ej[XL+:CW] == MX && o_ej[YL+:CW] == MY));

  assert_no_edge_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov & ~LINK) == 4'b0000);

  assert_defl_age_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aged_ok(o_n, o_n[YL+:CW] < MY));
  assert_defl_age_e_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aged_ok(o_e, o_e[XL+:CW] > MX));
  assert_defl_age_s_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aged_ok(o_s, o_s[YL+:CW] > MY));
  assert_defl_age_w_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aged_ok(o_w, o_w[XL+:CW] < MX));

  assert_ack_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ack |-> inj_v);
endmodule

bind defl_router defl_router_chk #(
  .CW(CW), .AW(AW), .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NODE_X(NODE_X), .NODE_Y(NODE_Y)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_v({in_w[0], in_s[0], in_e[0], in_n[0]}),
  .inj_v(inj_pkt[0]),
  .inj_ack(inj_ack),
  .o_n(out_n[2*CW+AW:0]),
  .o_e(out_e[2*CW+AW:0]),
  .o_s(out_s[2*CW+AW:0]),
  .o_w(out_w[2*CW+AW:0]),
  .o_ej(ej_pkt[2*CW:0])
);

// File: tb/sim_defl_router.sv
module sim_defl_router;
  typedef logic [127:0] pk_t;
  localparam int MS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  pk_t  drv [5];
  pk_t  o0 [5];
  pk_t  o1 [5];
  pk_t  e0 [5];
  pk_t  e1 [5];
  logic a0, a1;
  bit   ea0, ea1;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  defl_router #(.NODE_X(1), .NODE_Y(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_n(drv[0]), .in_e(drv[1]), .in_s(drv[2]), .in_w(drv[3]),
    .inj_pkt(drv[4]), .inj_ack(a0),
    .out_n(o0[0]), .out_e(o0[1]), .out_s(o0[2]), .out_w(o0[3]), .ej_pkt(o0[4])
  );

  defl_router #(.NODE_X(0), .NODE_Y(3)) u1 (
    .clk(clk), .rst_n(rst_n),
    .in_n(drv[0]), .in_e(drv[1]), .in_s(drv[2]), .in_w(drv[3]),
    .inj_pkt(drv[4]), .inj_ack(a1),
    .out_n(o1[0]), .out_e(o1[1]), .out_s(o1[2]), .out_w(o1[3]), .ej_pkt(o1[4])
  );

  function automatic pk_t mk(bit v, int x, int y, int age);
    pk_t r;
    r = {$urandom, $urandom, $urandom, $urandom};
    r[0]    = v;
    r[4:1]  = 4'(x);
    r[8:5]  = 4'(y);
    r[12:9] = 4'(age);
    return r;
  endfunction

  task automatic model(input int nx, input int ny, output pk_t eo [5], output bit ack);
    bit [3:0] lk;
    bit [4:0] v, used, busy;
    int nl, best, dx, dy, dst;
    pk_t p;
    lk   = {nx > 0, ny < MS - 1, nx < MS - 1, ny > 0};
    nl   = $countones(lk);
    v[3:0] = {drv[3][0], drv[2][0], drv[1][0], drv[0][0]} & lk;
    ack  = drv[4][0] && ($countones(v[3:0]) < nl);
    v[4] = ack;
    used = '0;
    busy = '0;
    for (int k = 0; k < 5; k++) eo[k] = '0;
    for (int n = 0; n < 5; n++) begin
      best = -1;
      for (int i = 0; i < 5; i++)
        if (v[i] && !used[i] && (best < 0 || drv[i][12:9] > drv[best][12:9])) best = i;
      if (best >= 0) begin
        used[best] = 1'b1;
        p   = drv[best];
        dx  = int'(p[4:1]);
        dy  = int'(p[8:5]);
        dst = -1;
        if (dx == nx && dy == ny && !busy[4]) dst = 4;
        if (dst < 0 && dx > nx && lk[1] && !busy[1]) dst = 1;
        if (dst < 0 && dx < nx && lk[3] && !busy[3]) dst = 3;
        if (dst < 0 && dy > ny && lk[2] && !busy[2]) dst = 2;
        if (dst < 0 && dy < ny && lk[0] && !busy[0]) dst = 0;
        for (int k = 0; k < 4; k++)
          if (dst < 0 && lk[k] && !busy[k]) begin
            dst = k;
            if (p[12:9] != 4'd15) p[12:9] = p[12:9] + 4'd1;
          end
        if (dst >= 0) begin
          busy[dst] = 1'b1;
          eo[dst]   = p;
        end
      end
    end
  endtask

  task automatic cmp(string tag, string what, pk_t act, pk_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag);
    #1;
    model(1, 2, e0, ea0);
    model(0, 3, e1, ea1);
    cmp(tag, "u0 inj_ack", pk_t'(a0), pk_t'(ea0));
    cmp(tag, "u1 inj_ack", pk_t'(a1), pk_t'(ea1));
    @(posedge clk);
    #2;
    for (int k = 0; k < 5; k++) begin
      cmp(tag, $sformatf("u0 port %0d", k), o0[k], e0[k]);
      cmp(tag, $sformatf("u1 port %0d", k), o1[k], e1[k]);
    end
    @(negedge clk);
  endtask

  task automatic clear();
    for (int k = 0; k < 5; k++) drv[k] = '0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    clear();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      cmp("R2", $sformatf("reset u0 port %0d", k), o0[k], '0);
      cmp("R2", $sformatf("reset u1 port %0d", k), o1[k], '0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R5: west arrival heading east; also ignored on the corner node (R9)
    clear(); drv[3] = mk(1, 3, 2, 0); run("R5");
    // R5: X before Y
    clear(); drv[0] = mk(1, 3, 3, 1); run("R5");
    // R4: two packets for u0, older ejected, younger deflected
    clear(); drv[0] = mk(1, 1, 2, 2); drv[2] = mk(1, 1, 2, 5); run("R4");
    // R4: injected local packet is ejected
    clear(); drv[4] = mk(1, 1, 2, 0); run("R4");
    // R6: equal ages contend for east
    clear(); drv[0] = mk(1, 3, 2, 1); drv[1] = mk(1, 3, 2, 1); run("R6");
    // R6: older packet from west beats north
    clear(); drv[0] = mk(1, 3, 2, 1); drv[3] = mk(1, 3, 2, 6); run("R6");
    // R7: saturated age stays at 15
    clear(); drv[0] = mk(1, 3, 2, 15); drv[1] = mk(1, 3, 2, 15); run("R7");
    // R8: all four valid, injection refused
    clear(); for (int k = 0; k < 5; k++) drv[k] = mk(1, 2, 0, k); run("R8");
    // R8: three valid, u0 accepts, corner u1 refuses
    clear(); drv[0] = mk(1, 0, 0, 0); drv[1] = mk(1, 2, 1, 0); drv[2] = mk(1, 3, 3, 0);
    drv[4] = mk(1, 0, 3, 0); run("R8");
    // R1: invalid packets with junk in other bits give zero outputs
    clear(); for (int k = 0; k < 5; k++) drv[k] = mk(0, 1, 2, 3); run("R1");
    // R9: corner node with both links busy toward east
    clear(); drv[0] = mk(1, 2, 3, 0); drv[1] = mk(1, 2, 3, 0); run("R9");
    // R9: inputs from missing south and west links of u1
    clear(); drv[2] = mk(1, 0, 3, 0); drv[3] = mk(1, 0, 3, 0); run("R9");

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 5; k++)
        drv[k] = mk(($urandom % 10) < 6, $urandom % MS, $urandom % MS,
                     (($urandom % 8) == 0) ? 15 : ($urandom % 16));
      run("R3");
    end
    clear();
    run("R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule